// File: doc/BRIEF.md
# Exception Entry and Vector Selector

This block performs the architectural state update that a small processor core needs on the cycle it takes an exception. It receives a general-exception request with a cause code, a separate debug-exception request with its own cause code, the faulting PC, an optional faulting virtual address and the current status word. In one clock edge it writes the saved-PC registers, the cause registers and the virtual-address register. It also produces the new status word and emits a one-cycle vector-valid pulse with a 2-bit vector code.

If the exception-mode bit is already set, a general exception goes to the double-exception path. If it is clear, the user-mode bit picks the user or kernel vector. A debug exception is taken only below the configured debug level. When taken, it stores the PC and the old status word in registers indexed by that level. It raises the interrupt level to the debug level, and it wins over a general request raised in the same cycle.

Status word layout: bits [3:0] hold the interrupt level, bit 4 is the exception-mode bit and bit 5 is the user-mode bit. The block does not change the other bits. Vector codes are user = 0, kernel = 1, double = 2 and debug = 3.

Top module: `exc_entry_top`

## Requirements
- R1: While rst_ni is low and after its release, every saved register, status_o and vec_valid_o read zero.
- R2: A general request with status bit 4 clear and bit 5 set writes fault_pc_i into epc_o level 1 and selects vector code 0 (user).
- R3: A general request with status bits 4 and 5 both clear writes fault_pc_i into epc_o level 1 and selects vector code 1 (kernel).
- R4: With HAS_DEPC = 1, a general request with status bit 4 set writes fault_pc_i into depc_o, leaves epc_o level 1 unchanged and selects vector code 2 (double).
- R5: With HAS_DEPC = 0, a general request with status bit 4 set writes fault_pc_i into epc_o level 1 and still selects vector code 2.
- R6: Every taken general exception loads cause_o with cause_i and drives status_o equal to status_i with bit 4 set.
- R7: A taken general exception loads vaddr_o from vaddr_i only when has_vaddr_i is high; otherwise vaddr_o keeps its value.
- R8: A debug request is taken only when status_i[3:0] is below DEBUG_LEVEL. Otherwise it changes no register and produces no pulse.
- R9: A taken debug exception loads dcause_o and writes fault_pc_i into epc_o at level DEBUG_LEVEL. It writes status_i into eps_o at level DEBUG_LEVEL. It drives status_o with bits [3:0] = DEBUG_LEVEL, bit 4 set and all other bits kept, and it selects vector code 3.
- R10: When a debug exception is taken in the same cycle as a general request, cause_o, vaddr_o, depc_o and epc_o level 1 keep their values.
- R11: vec_valid_o is high for exactly the cycle after a taken request and low after any cycle without one, and all registers hold when no request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gen_req_i | input | 1 | General exception request |
| cause_i | input | CAUSE_W | General exception cause code |
| has_vaddr_i | input | 1 | The exception carries a faulting address |
| vaddr_i | input | XLEN | Faulting virtual address |
| dbg_req_i | input | 1 | Debug exception request |
| dcause_i | input | DCAUSE_W | Debug cause code |
| fault_pc_i | input | XLEN | PC of the faulting instruction |
| status_i | input | XLEN | Current status word |
| vec_valid_o | output | 1 | One-cycle vector-select pulse |
| vec_code_o | output | 2 | Vector code: 0 user, 1 kernel, 2 double, 3 debug |
| status_o | output | XLEN | Status word produced by the last entry |
| cause_o | output | CAUSE_W | General cause register |
| vaddr_o | output | XLEN | Exception virtual-address register |
| dcause_o | output | DCAUSE_W | Debug cause register |
| depc_o | output | XLEN | Double-exception PC register |
| epc_o | output | DEBUG_LEVEL x XLEN | Per-level exception PC registers, levels 1..DEBUG_LEVEL |
| eps_o | output | (DEBUG_LEVEL-1) x XLEN | Per-level saved status registers, levels 2..DEBUG_LEVEL |

## Verification
Some properties are checked on every cycle. Each pulse follows a request. Every pulse sets the exception-mode bit. A debug vector implies the level was below DEBUG_LEVEL and that the new status carries DEBUG_LEVEL. A double vector implies the exception-mode bit was already set. Cause tracks a general entry and holds when idle. Only the bench scenarios can show the routing of the PC between depc_o and the level registers, the saving of status into eps_o, the conditional address capture and the masking of general state under debug priority. These scenarios include a second instance built without the double-exception PC register.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    VEC_USER   = 2'd0,
    VEC_KERNEL = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  localparam int ST_LVL_LSB = 0;
  localparam int ST_LVL_W   = 4;
  localparam int ST_EXCM    = 4;
  localparam int ST_UM      = 5;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int DEBUG_LEVEL = 6,
  parameter int LVL_W       = 4
) (
  input  logic             gen_req_i,
  input  logic             dbg_req_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  output logic             take_gen_o,
  output logic             take_dbg_o
);
  localparam logic [LVL_W-1:0] DBG_LVL = LVL_W'(DEBUG_LEVEL);

  always_comb begin
    take_dbg_o = dbg_req_i && (cur_lvl_i < DBG_LVL);
    take_gen_o = gen_req_i && !take_dbg_o;
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic take_gen_i,
  input  logic take_dbg_i,
  input  logic excm_i,
  input  logic um_i,
  output vec_e vec_o,
  output logic depc_we_o
);
  always_comb begin
    if (take_dbg_i)  vec_o = VEC_DEBUG;
    else if (excm_i) vec_o = VEC_DOUBLE;
    else if (um_i)   vec_o = VEC_USER;
    else             vec_o = VEC_KERNEL;
    depc_we_o = HAS_DEPC && take_gen_i && excm_i;
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 6,
  parameter int DCAUSE_W    = 6,
  parameter int DEBUG_LEVEL = 6
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               take_gen_i,
  input  logic                               take_dbg_i,
  input  logic                               depc_we_i,
  input  vec_e                               vec_i,
  input  logic [CAUSE_W-1:0]                 cause_i,
  input  logic [DCAUSE_W-1:0]                dcause_i,
  input  logic [XLEN-1:0]                    pc_i,
  input  logic                               has_vaddr_i,
  input  logic [XLEN-1:0]                    vaddr_i,
  input  logic [XLEN-1:0]                    status_i,
  output logic                               vec_valid_o,
  output logic [1:0]                         vec_code_o,
  output logic [XLEN-1:0]                    status_o,
  output logic [CAUSE_W-1:0]                 cause_o,
  output logic [XLEN-1:0]                    vaddr_o,
  output logic [DCAUSE_W-1:0]                dcause_o,
  output logic [XLEN-1:0]                    depc_o,
  output logic [DEBUG_LEVEL:1][XLEN-1:0]     epc_o,
  output logic [DEBUG_LEVEL:2][XLEN-1:0]     eps_o
);
  localparam logic [XLEN-1:0] LVL_MASK  = XLEN'(((1 << ST_LVL_W) - 1) << ST_LVL_LSB);
  localparam logic [XLEN-1:0] EXCM_BIT  = XLEN'(1) << ST_EXCM;
  localparam logic [XLEN-1:0] DBG_FIELD = XLEN'(DEBUG_LEVEL) << ST_LVL_LSB;

  logic            take_any;
  logic [XLEN-1:0] st_next;

  always_comb begin
    take_any = take_gen_i || take_dbg_i;
    if (take_dbg_i) st_next = (status_i & ~LVL_MASK) | DBG_FIELD | EXCM_BIT;
    else            st_next = status_i | EXCM_BIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      vec_code_o  <= '0;
      status_o    <= '0;
      cause_o     <= '0;
      vaddr_o     <= '0;
      dcause_o    <= '0;
      depc_o      <= '0;
    end else begin
      vec_valid_o <= take_any;
      if (take_any) begin
        vec_code_o <= vec_i;
        status_o   <= st_next;
      end
      if (take_gen_i) cause_o <= cause_i;
      if (take_gen_i && has_vaddr_i) vaddr_o <= vaddr_i;
      if (take_dbg_i) dcause_o <= dcause_i;
      if (depc_we_i) depc_o <= pc_i;
    end
  end

  for (genvar l = 1; l <= DEBUG_LEVEL; l++) begin : g_epc
    logic we;
    assign we = ((l == 1) && take_gen_i && !depc_we_i) ||
                ((l == DEBUG_LEVEL) && take_dbg_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  epc_o[l] <= '0;
      else if (we)  epc_o[l] <= pc_i;
    end
  end

  for (genvar l = 2; l <= DEBUG_LEVEL; l++) begin : g_eps
    logic we;
    assign we = (l == DEBUG_LEVEL) && take_dbg_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  eps_o[l] <= '0;
      else if (we)  eps_o[l] <= status_i;
    end
  end
endmodule

// File: rtl/exc_entry_top.sv
module exc_entry_top
  import exc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 6,
  parameter int DCAUSE_W    = 6,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           gen_req_i,
  input  logic [CAUSE_W-1:0]             cause_i,
  input  logic                           has_vaddr_i,
  input  logic [XLEN-1:0]                vaddr_i,
  input  logic                           dbg_req_i,
  input  logic [DCAUSE_W-1:0]            dcause_i,
  input  logic [XLEN-1:0]                fault_pc_i,
  input  logic [XLEN-1:0]                status_i,
  output logic                           vec_valid_o,
  output logic [1:0]                     vec_code_o,
  output logic [XLEN-1:0]                status_o,
  output logic [CAUSE_W-1:0]             cause_o,
  output logic [XLEN-1:0]                vaddr_o,
  output logic [DCAUSE_W-1:0]            dcause_o,
  output logic [XLEN-1:0]                depc_o,
  output logic [DEBUG_LEVEL:1][XLEN-1:0] epc_o,
  output logic [DEBUG_LEVEL:2][XLEN-1:0] eps_o
);
  logic take_gen, take_dbg, depc_we;
  vec_e vec;

  exc_arbiter #(.DEBUG_LEVEL(DEBUG_LEVEL), .LVL_W(ST_LVL_W)) u_arb (
    .gen_req_i  (gen_req_i),
    .dbg_req_i  (dbg_req_i),
    .cur_lvl_i  (status_i[ST_LVL_LSB +: ST_LVL_W]),
    .take_gen_o (take_gen),
    .take_dbg_o (take_dbg)
  );

  exc_vector_sel #(.HAS_DEPC(HAS_DEPC)) u_vsel (
    .take_gen_i (take_gen),
    .take_dbg_i (take_dbg),
    .excm_i     (status_i[ST_EXCM]),
    .um_i       (status_i[ST_UM]),
    .vec_o      (vec),
    .depc_we_o  (depc_we)
  );

  exc_state_regs #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W), .DEBUG_LEVEL(DEBUG_LEVEL)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_gen_i  (take_gen),
    .take_dbg_i  (take_dbg),
    .depc_we_i   (depc_we),
    .vec_i       (vec),
    .cause_i     (cause_i),
    .dcause_i    (dcause_i),
    .pc_i        (fault_pc_i),
    .has_vaddr_i (has_vaddr_i),
    .vaddr_i     (vaddr_i),
    .status_i    (status_i),
    .vec_valid_o (vec_valid_o),
    .vec_code_o  (vec_code_o),
    .status_o    (status_o),
    .cause_o     (cause_o),
    .vaddr_o     (vaddr_o),
    .dcause_o    (dcause_o),
    .depc_o      (depc_o),
    .epc_o       (epc_o),
    .eps_o       (eps_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 6,
  parameter int DEBUG_LEVEL = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               gen_req_i,
  input logic               dbg_req_i,
  input logic [CAUSE_W-1:0] cause_i,
  input logic [XLEN-1:0]    status_i,
  input logic               vec_valid_o,
  input logic [1:0]         vec_code_o,
  input logic [XLEN-1:0]    status_o,
  input logic [CAUSE_W-1:0] cause_o
);
  localparam logic [ST_LVL_W-1:0] DBG_LVL = ST_LVL_W'(DEBUG_LEVEL);

  AST_PULSE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(gen_req_i || dbg_req_i)); // R11
  AST_IDLE_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gen_req_i || dbg_req_i) |=> !vec_valid_o); // R11
  AST_ENTRY_SETS_EXCM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> status_o[ST_EXCM]); // R6
  AST_GEN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && vec_code_o != VEC_DEBUG) |-> cause_o == $past(cause_i)); // R6
  AST_DBG_BELOW_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && vec_code_o == VEC_DEBUG) |->
      $past(status_i[ST_LVL_LSB +: ST_LVL_W]) < DBG_LVL); // R8
  AST_DBG_NEW_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && vec_code_o == VEC_DEBUG) |->
      status_o[ST_LVL_LSB +: ST_LVL_W] == DBG_LVL); // R9
  AST_DOUBLE_NEEDS_EXCM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && vec_code_o == VEC_DOUBLE) |-> $past(status_i[ST_EXCM])); // R4
  AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(gen_req_i) |-> $stable(cause_o)); // R11
endmodule

bind exc_entry_top exc_entry_chk #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DEBUG_LEVEL(DEBUG_LEVEL)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gen_req_i   (gen_req_i),
  .dbg_req_i   (dbg_req_i),
  .cause_i     (cause_i),
  .status_i    (status_i),
  .vec_valid_o (vec_valid_o),
  .vec_code_o  (vec_code_o),
  .status_o    (status_o),
  .cause_o     (cause_o)
);

// File: tb/exc_entry_top_tb.sv
module exc_entry_top_tb;
  localparam int XL = 32;
  localparam int CW = 6;
  localparam int DL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          gen_req = 0, has_va = 0, dbg_req = 0;
  logic [CW-1:0] cause = '0, dcause = '0;
  logic [XL-1:0] va = '0, pc = '0, st = '0;

  logic          vv;
  logic [1:0]    vc;
  logic [XL-1:0] st_o, va_o, depc_o;
  logic [CW-1:0] c_o, dc_o;
  logic [DL:1][XL-1:0] epc_o;
  logic [DL:2][XL-1:0] eps_o;

  logic          n_vv;
  logic [1:0]    n_vc;
  logic [XL-1:0] n_st, n_va, n_depc;
  logic [CW-1:0] n_c, n_dc;
  logic [DL:1][XL-1:0] n_epc;
  logic [DL:2][XL-1:0] n_eps;

  exc_entry_top #(.XLEN(XL), .CAUSE_W(CW), .DCAUSE_W(CW), .DEBUG_LEVEL(DL), .HAS_DEPC(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gen_req_i(gen_req), .cause_i(cause), .has_vaddr_i(has_va),
    .vaddr_i(va), .dbg_req_i(dbg_req), .dcause_i(dcause), .fault_pc_i(pc), .status_i(st),
    .vec_valid_o(vv), .vec_code_o(vc), .status_o(st_o), .cause_o(c_o), .vaddr_o(va_o),
    .dcause_o(dc_o), .depc_o(depc_o), .epc_o(epc_o), .eps_o(eps_o));

  exc_entry_top #(.XLEN(XL), .CAUSE_W(CW), .DCAUSE_W(CW), .DEBUG_LEVEL(DL), .HAS_DEPC(1'b0)) u_dut_nodepc (
    .clk_i(clk), .rst_ni(rst_n), .gen_req_i(gen_req), .cause_i(cause), .has_vaddr_i(has_va),
    .vaddr_i(va), .dbg_req_i(dbg_req), .dcause_i(dcause), .fault_pc_i(pc), .status_i(st),
    .vec_valid_o(n_vv), .vec_code_o(n_vc), .status_o(n_st), .cause_o(n_c), .vaddr_o(n_va),
    .dcause_o(n_dc), .depc_o(n_depc), .epc_o(n_epc), .eps_o(n_eps));

  int n_chk = 0, n_bad = 0;
  string cur_tag = "R1", m_tag = "R1";

  // behavioural reference of the HAS_DEPC=1 instance
  bit          m_vv;
  int unsigned m_vc, m_st, m_c, m_va, m_dc, m_depc;
  int unsigned m_epc[1:DL];
  int unsigned m_eps[2:DL];

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vv = 0; m_vc = 0; m_st = 0; m_c = 0; m_va = 0; m_dc = 0; m_depc = 0;
      foreach (m_epc[i]) m_epc[i] = 0;
      foreach (m_eps[i]) m_eps[i] = 0;
      m_tag = cur_tag;
    end else begin
      bit dbg_ok;
      dbg_ok = dbg_req && ((st & 32'hF) < DL);
      m_tag = cur_tag;
      m_vv = dbg_ok || gen_req;
      if (dbg_ok) begin
        m_dc = dcause; m_epc[DL] = pc; m_eps[DL] = st;
        m_st = (st & ~32'hF) | DL | 32'h10; m_vc = 3;
      end else if (gen_req) begin
        m_c = cause;
        if (has_va) m_va = va;
        m_st = st | 32'h10;
        if (st[4]) begin m_depc = pc; m_vc = 2; end
        else begin m_epc[1] = pc; m_vc = st[5] ? 0 : 1; end
      end
    end
  end

  always @(negedge clk) begin
    chk(m_tag, "vec_valid", vv, m_vv);
    if (m_vv) chk(m_tag, "vec_code", vc, m_vc);
    chk(m_tag, "status", st_o, m_st);
    chk(m_tag, "cause", c_o, m_c);
    chk(m_tag, "vaddr", va_o, m_va);
    chk(m_tag, "dcause", dc_o, m_dc);
    chk(m_tag, "depc", depc_o, m_depc);
    for (int l = 1; l <= DL; l++) chk(m_tag, $sformatf("epc%0d", l), epc_o[l], m_epc[l]);
    for (int l = 2; l <= DL; l++) chk(m_tag, $sformatf("eps%0d", l), eps_o[l], m_eps[l]);
  end

  task automatic fire(string tag, bit g, bit d, int unsigned s, int unsigned p,
                      bit hv, int unsigned a, int unsigned c);
    @(negedge clk);
    cur_tag = tag;
    gen_req = g; dbg_req = d; st = s; pc = p; has_va = hv; va = a;
    cause = CW'(c); dcause = CW'(c + 7);
    @(negedge clk);
    gen_req = 0; dbg_req = 0; has_va = 0;
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        fire("R2_R7",  1, 0, 32'h0000_0020, 32'h1000_0004, 1, 32'hDEAD_0000, 5);
        fire("R3_R7",  1, 0, 32'h0000_0000, 32'h1000_0008, 0, 32'hBEEF_0000, 9);
        fire("R4_R6",  1, 0, 32'h0000_0012, 32'h1000_000C, 1, 32'h0000_0444, 3);
        if (epc_o[1] !== 32'h1000_0008) begin n_bad++; $display("FAIL R4 epc1 kept: actual=%0h expected=10000008", epc_o[1]); end
        n_chk++;
        // R5: instance without double-exception PC
        n_chk++;
        if (n_epc[1] !== 32'h1000_000C || n_vc !== 2'd2 || n_depc !== 0) begin
          n_bad++;
          $display("FAIL R5 epc1=%0h vec=%0d depc=%0h expected 1000000c/2/0", n_epc[1], n_vc, n_depc);
        end
        fire("R9",     0, 1, 32'h8000_0022, 32'h2000_0000, 0, 0, 1);
        fire("R8",     0, 1, 32'h0000_0006, 32'h2000_0010, 0, 0, 2);
        fire("R8",     0, 1, 32'h0000_0007, 32'h2000_0020, 0, 0, 4);
        fire("R10",    1, 1, 32'h0000_0000, 32'h3000_0000, 1, 32'h5555_5555, 6);
        fire("R8_R10", 1, 1, 32'h0000_0026, 32'h3000_0004, 1, 32'h6666_0000, 8);
        fire("R9",     0, 1, 32'h0000_0035, 32'h3000_0008, 0, 0, 10);
        fire("R2",     1, 0, 32'h0000_0025, 32'h3000_000C, 0, 0, 11);
        cur_tag = "R11";
        repeat (4) @(negedge clk);
        @(negedge clk);
      end
      begin
        while (wd < 5000) begin @(posedge clk); wd++; end
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule